// File: doc/BRIEF.md
# Exception Target Level Router

This block picks the exception level that takes an exception and works out the control bits that the virtualization settings override. It looks only at the programmed configuration and the current level, so it is purely combinational. The stored register values pass through the block unchanged. Register read and write paths tap those stored values directly, while the execution logic uses the effective outputs computed here.

The forcing depends on three stored bits: the security bit (0 = Secure, 1 = Non-secure), the trap-general bit and the host-extension bit. The trap-general bit only counts in the Non-secure state. When it counts, exceptions that would go to EL1 are sent to EL2 instead. In that case the EL1 stage-1 MMU enable reads as 0 to the execution logic, virtual interrupts are switched off, and a return that targets EL1 is flagged as illegal. When the host-extension bit is also 0, the interrupt-routing bits and the debug-trap bits are forced to 1 as well.

Top module: `exc_route_top`

## Requirements
- R1: When `sec_ns` is 0, `tgt_el` is never 2 (EL2); a target that would be EL2 becomes EL3.
- R2: When `sec_ns` is 0, `trap_gen` has no effect on any output.
- R3: When `sec_ns`=1 and `trap_gen`=1, a nominal target of EL1 (value 1) yields `tgt_el`=2 if `cur_el` is at most 2.
- R4: `el1_mmu_eff` is 0 when `sec_ns`=1 and `trap_gen`=1; otherwise it equals `el1_mmu_en`.
- R5: `virq_en` is 0 when `sec_ns`=1 and `trap_gen`=1, and 1 otherwise.
- R6: `ret_illegal` is 1 only while `ret_req`=1, and then only for one of two cases. The first is `ret_el`=1 with `sec_ns`=1 and `trap_gen`=1. The second is `ret_el`=2 with `sec_ns`=0.
- R7: When `sec_ns`=1, `trap_gen`=1 and `host_ext`=0, `route_eff` is all ones; otherwise it equals `route_cfg` (bit 0 FIQ, bit 1 IRQ, bit 2 SError).
- R8: Under the same condition as R7, `dbg_trap_eff` is all ones; otherwise it equals `dbg_trap_cfg`. The bits are: bit 0 debug ROM access, bit 1 OS debug registers, bit 2 debug register access, bit 3 debug exception routing.
- R9: `tgt_el` is never lower than `cur_el`.
- R10: A nominal target of EL0 is handled as EL1, since exceptions are never taken to EL0.
- R11: When `host_ext`=1, the EL1-to-EL2 redirection of R3 still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sec_ns | input | 1 | Stored security bit, 1 = Non-secure |
| trap_gen | input | 1 | Stored trap-general-exceptions bit |
| host_ext | input | 1 | Stored host-extension bit |
| route_cfg | input | 3 | Stored FIQ/IRQ/SError routing bits |
| dbg_trap_cfg | input | 4 | Stored debug trap bits |
| el1_mmu_en | input | 1 | Stored EL1 stage-1 MMU enable |
| cur_el | input | 2 | Current exception level |
| nom_el | input | 2 | Nominal target level of the exception |
| ret_req | input | 1 | An exception return is requested |
| ret_el | input | 2 | Level the return targets |
| tgt_el | output | 2 | Final target level |
| route_eff | output | 3 | Effective routing bits |
| dbg_trap_eff | output | 4 | Effective debug trap bits |
| el1_mmu_eff | output | 1 | Effective EL1 stage-1 MMU enable |
| virq_en | output | 1 | Virtual interrupts enabled |
| ret_illegal | output | 1 | Requested return is illegal |

## Verification
The assertions run on every evaluation and check the invariants of the block. Secure state never yields EL2, the target never drops below the current level, and forcing only ever sets bits. The MMU enable is only ever cleared, never set. A flagged return always has a request behind it, and the redirect to EL2 happens under the trap condition. Only the bench scenarios can show the other properties, because each needs a comparison between input patterns. These are that the trap bit really has no effect in Secure state, that the stored values pass through unchanged when no forcing applies, and that the host-extension bit removes the forcing while keeping the redirect.

// File: rtl/exc_route_pkg.sv
package exc_route_pkg;
  localparam int EL_W     = 2;
  localparam int ROUTE_W  = 3;
  localparam int DTRAP_W  = 4;

  typedef logic [EL_W-1:0] el_t;
  localparam el_t EL0 = 2'd0;
  localparam el_t EL1 = 2'd1;
  localparam el_t EL2 = 2'd2;
  localparam el_t EL3 = 2'd3;

  // higher of two levels
  function automatic el_t el_max(input el_t a, input el_t b);
    return (a > b) ? a : b;
  endfunction

  // full routing decision from the effective trap state
  function automatic el_t route_level(input el_t nom, input el_t cur,
                                      input logic ns, input logic trap_eff);
    el_t lvl;
    lvl = (nom == EL0) ? EL1 : nom;
    if (trap_eff && lvl == EL1) lvl = EL2;
    lvl = el_max(lvl, cur);
    if (!ns && lvl == EL2) lvl = EL3;
    return lvl;
  endfunction
endpackage

// File: rtl/exc_ctrl_eff.sv
module exc_ctrl_eff
  import exc_route_pkg::*;
#(
  parameter int RW = ROUTE_W,
  parameter int DW = DTRAP_W
) (
  input  logic          ns,
  input  logic          trap_gen,
  input  logic          host_ext,
  input  logic [RW-1:0] route_cfg,
  input  logic [DW-1:0] dbg_cfg,
  input  logic          mmu_cfg,
  output logic          trap_eff,
  output logic          force_ovr,
  output logic [RW-1:0] route_eff,
  output logic [DW-1:0] dbg_eff,
  output logic          mmu_eff,
  output logic          virq_en
);
  assign trap_eff  = ns & trap_gen;
  assign force_ovr = trap_eff & ~host_ext;
  assign mmu_eff   = mmu_cfg & ~trap_eff;
  assign virq_en   = ~trap_eff;

  for (genvar i = 0; i < RW; i++) begin : g_route
    assign route_eff[i] = route_cfg[i] | force_ovr;
  end
  for (genvar j = 0; j < DW; j++) begin : g_dbg
    assign dbg_eff[j] = dbg_cfg[j] | force_ovr;
  end
endmodule

// File: rtl/exc_target_sel.sv
module exc_target_sel
  import exc_route_pkg::*;
(
  input  el_t  nom_el,
  input  el_t  cur_el,
  input  logic ns,
  input  logic trap_eff,
  output el_t  tgt_el,
  output logic redirected
);
  assign tgt_el     = route_level(nom_el, cur_el, ns, trap_eff);
  assign redirected = trap_eff & ((nom_el == EL0) | (nom_el == EL1));
endmodule

// File: rtl/exc_ret_check.sv
module exc_ret_check
  import exc_route_pkg::*;
(
  input  logic ret_req,
  input  el_t  ret_el,
  input  logic ns,
  input  logic trap_eff,
  output logic ret_illegal
);
  logic to_el1_trapped;
  logic to_el2_secure;
  assign to_el1_trapped = trap_eff & (ret_el == EL1);
  assign to_el2_secure  = ~ns & (ret_el == EL2);
  assign ret_illegal    = ret_req & (to_el1_trapped | to_el2_secure);
endmodule

// File: rtl/exc_route_top.sv
module exc_route_top
  import exc_route_pkg::*;
(
  input  logic               sec_ns,
  input  logic               trap_gen,
  input  logic               host_ext,
  input  logic [ROUTE_W-1:0] route_cfg,
  input  logic [DTRAP_W-1:0] dbg_trap_cfg,
  input  logic               el1_mmu_en,
  input  logic [EL_W-1:0]    cur_el,
  input  logic [EL_W-1:0]    nom_el,
  input  logic               ret_req,
  input  logic [EL_W-1:0]    ret_el,
  output logic [EL_W-1:0]    tgt_el,
  output logic [ROUTE_W-1:0] route_eff,
  output logic [DTRAP_W-1:0] dbg_trap_eff,
  output logic               el1_mmu_eff,
  output logic               virq_en,
  output logic               ret_illegal
);
  logic trap_eff;
  logic force_ovr;
  logic redirected;

  exc_ctrl_eff #(.RW(ROUTE_W), .DW(DTRAP_W)) u_ctrl (
    .ns(sec_ns), .trap_gen(trap_gen), .host_ext(host_ext),
    .route_cfg(route_cfg), .dbg_cfg(dbg_trap_cfg), .mmu_cfg(el1_mmu_en),
    .trap_eff(trap_eff), .force_ovr(force_ovr), .route_eff(route_eff),
    .dbg_eff(dbg_trap_eff), .mmu_eff(el1_mmu_eff), .virq_en(virq_en)
  );

  exc_target_sel u_sel (
    .nom_el(nom_el), .cur_el(cur_el), .ns(sec_ns), .trap_eff(trap_eff),
    .tgt_el(tgt_el), .redirected(redirected)
  );

  exc_ret_check u_ret (
    .ret_req(ret_req), .ret_el(ret_el), .ns(sec_ns), .trap_eff(trap_eff),
    .ret_illegal(ret_illegal)
  );
endmodule

// File: rtl/exc_route_chk.sv
module exc_route_chk
  import exc_route_pkg::*;
(
  input logic               sec_ns,
  input logic               trap_gen,
  input logic [ROUTE_W-1:0] route_cfg,
  input logic [DTRAP_W-1:0] dbg_trap_cfg,
  input logic               el1_mmu_en,
  input logic [EL_W-1:0]    cur_el,
  input logic [EL_W-1:0]    nom_el,
  input logic               ret_req,
  input logic [EL_W-1:0]    tgt_el,
  input logic [ROUTE_W-1:0] route_eff,
  input logic [DTRAP_W-1:0] dbg_trap_eff,
  input logic               el1_mmu_eff,
  input logic               virq_en,
  input logic               ret_illegal
);
  always_comb begin
    // R1
    secure_no_el2_chk: assert (sec_ns || tgt_el != EL2);
    // R9
    no_downward_chk: assert (tgt_el >= cur_el);
    // R3
    tge_redirect_chk: assert (!(sec_ns && trap_gen && nom_el == EL1 && cur_el <= EL2) || tgt_el == EL2);
    // R4
    mmu_only_cleared_chk: assert (!el1_mmu_eff || el1_mmu_en);
    // R5
    virq_off_chk: assert (!(sec_ns && trap_gen) || !virq_en);
    // R7
    route_only_set_chk: assert ((route_eff & route_cfg) == route_cfg);
    // R8
    dbg_only_set_chk: assert ((dbg_trap_eff & dbg_trap_cfg) == dbg_trap_cfg);
    // R6
    ret_needs_req_chk: assert (ret_req || !ret_illegal);
  end
endmodule

bind exc_route_top exc_route_chk u_chk (
  .sec_ns(sec_ns), .trap_gen(trap_gen), .route_cfg(route_cfg),
  .dbg_trap_cfg(dbg_trap_cfg), .el1_mmu_en(el1_mmu_en), .cur_el(cur_el),
  .nom_el(nom_el), .ret_req(ret_req), .tgt_el(tgt_el), .route_eff(route_eff),
  .dbg_trap_eff(dbg_trap_eff), .el1_mmu_eff(el1_mmu_eff), .virq_en(virq_en),
  .ret_illegal(ret_illegal)
);

// File: tb/tb_exc_route_top.sv
module tb_exc_route_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       sec_ns, trap_gen, host_ext, el1_mmu_en, ret_req;
  logic [2:0] route_cfg;
  logic [3:0] dbg_trap_cfg;
  logic [1:0] cur_el, nom_el, ret_el;
  logic [1:0] tgt_el;
  logic [2:0] route_eff;
  logic [3:0] dbg_trap_eff;
  logic       el1_mmu_eff, virq_en, ret_illegal;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  exc_route_top dut (.*);

  // {ns,tge,e2h,mmu,cur,nom, exp_tgt,exp_mmu,exp_virq}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    12'b0001_00_01_01_1_1,  // base secure
    12'b0101_00_01_01_1_1,  // R2 tge ignored in secure
    12'b1101_00_01_10_0_0,  // R3 R4 R5
    12'b1111_00_01_10_0_0,  // R11 e2h keeps redirect
    12'b1001_00_01_01_1_1,  // ns, no tge
    12'b1100_00_11_11_0_0,  // nominal EL3 untouched
    12'b0000_00_10_11_0_1,  // R1 secure EL2 -> EL3
    12'b1001_10_01_10_1_1,  // R9 raise to current
    12'b1001_11_01_11_1_1,  // R9 from EL3
    12'b1000_00_00_01_0_1,  // R10 EL0 as EL1
    12'b1101_00_00_10_0_0,  // R10 then R3
    12'b0001_01_00_01_1_1   // R10 secure
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setcfg(input logic ns, input logic tge, input logic e2h);
    sec_ns = ns; trap_gen = tge; host_ext = e2h;
    @(negedge clk);
  endtask

  initial begin
    sec_ns = 0; trap_gen = 0; host_ext = 0; el1_mmu_en = 0; ret_req = 0;
    route_cfg = 0; dbg_trap_cfg = 0; cur_el = 0; nom_el = 0; ret_el = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // idle state: all-zero configuration
    chk("R10 idle tgt", tgt_el, 2'd1);
    chk("R7 idle route", route_eff, 3'b000);
    chk("R6 idle ret", ret_illegal, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {sec_ns, trap_gen, host_ext, el1_mmu_en} = VEC[i][11:8];
      cur_el = VEC[i][7:6];
      nom_el = VEC[i][5:4];
      @(negedge clk);
      chk($sformatf("R3/R9 vec%0d tgt", i), tgt_el, VEC[i][3:2]);
      chk($sformatf("R4 vec%0d mmu", i), el1_mmu_eff, VEC[i][1]);
      chk($sformatf("R5 vec%0d virq", i), virq_en, VEC[i][0]);
    end

    // R7 / R8 forcing and pass-through
    route_cfg = 3'b010; dbg_trap_cfg = 4'b0100;
    setcfg(1, 1, 0);
    chk("R7 forced", route_eff, 3'b111);
    chk("R8 forced", dbg_trap_eff, 4'b1111);
    setcfg(1, 1, 1);
    chk("R11 route pass", route_eff, 3'b010);
    chk("R11 dbg pass", dbg_trap_eff, 4'b0100);
    setcfg(0, 1, 0);
    chk("R2 route pass", route_eff, 3'b010);
    chk("R2 dbg pass", dbg_trap_eff, 4'b0100);
    setcfg(1, 0, 0);
    chk("R8 no tge", dbg_trap_eff, 4'b0100);

    // R6 returns
    ret_req = 1; ret_el = 2'd1;
    setcfg(1, 1, 0);
    chk("R6 ret EL1 trapped", ret_illegal, 1'b1);
    setcfg(1, 0, 0);
    chk("R6 ret EL1 ok", ret_illegal, 1'b0);
    setcfg(0, 1, 0);
    chk("R2 ret EL1 secure", ret_illegal, 1'b0);
    ret_el = 2'd2;
    setcfg(0, 0, 0);
    chk("R6 ret EL2 secure", ret_illegal, 1'b1);
    setcfg(1, 1, 0);
    chk("R6 ret EL2 ns", ret_illegal, 1'b0);
    ret_req = 0; ret_el = 2'd1;
    setcfg(1, 1, 0);
    chk("R6 no req", ret_illegal, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule